// File: doc/BRIEF.md
# Backward-Determinism Checker

The block holds the next-state relation of a finite machine with a parameterised number of states and input words. It decides whether that machine is backwards deterministic. The relation is loaded through a write port. Each (input word, source state) slot holds a target state and a flag that says whether the slot is in use. Unused slots stand for the empty entries of the direct-transition matrix: no input word carries the machine along that row/column pair.

After a start request the block walks every slot once, one slot per clock. For each used slot it marks the (input, target) pair in a bitmap of pairs already reached. If a pair is reached a second time, the machine has two predecessors for one (input, state) combination. That means the earlier state sequence cannot be recovered uniquely from the input history and the final state, so the check fails. The block reports a single verdict and the first offending (input, target) pair. It keeps that result until the next accepted start.

Top module: `bd_checker`

## Requirements
- R1: After reset, `busy`, `done`, `result_valid` and `pass` are 0, `bad_in` and `bad_dst` are 0, and every table slot is unused, so a scan of a table that was never written passes.
- R2: While idle, a write with `wr_en`=1 stores `wr_valid` and `wr_dst` into the slot addressed by (`wr_in`, `wr_src`), replacing any earlier content. Writes presented while `busy`=1 are discarded.
- R3: A start pulse while idle is accepted on that clock edge, and `busy` reads 1 after it. A start while `busy`=1 is ignored and does not lengthen or restart the scan.
- R4: `done` is a single-cycle pulse exactly NUM_INPUTS*NUM_STATES clock edges after the edge that accepted start. `busy` stays 1 from the accepting edge until `done` rises, and `busy` and `done` are never 1 together.
- R5: `pass`=1 exactly when no (input, target) pair is reached by two or more used slots.
- R6: Slots marked unused (`wr_valid`=0) are skipped and never count as a predecessor.
- R7: Slots are scanned with the input word as the outer loop and the source state as the inner loop, both ascending. On failure, `bad_in` and `bad_dst` give the input word and the target state of the first slot found to be a second predecessor. On a pass, both read 0.
- R8: `result_valid` rises with `done`. Afterwards `result_valid`, `pass`, `bad_in` and `bad_dst` hold their values until the next accepted start, and that start clears `result_valid`.
- R9: Every scan starts from an empty predecessor bitmap, so its verdict depends only on the current table contents and not on earlier scans.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_in | input | $clog2(NUM_INPUTS) | Input word of the slot written |
| wr_src | input | $clog2(NUM_STATES) | Source state of the slot written |
| wr_valid | input | 1 | 1 = slot in use, 0 = empty entry |
| wr_dst | input | $clog2(NUM_STATES) | Target state stored in the slot |
| start | input | 1 | Request a scan |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle pulse at end of scan |
| result_valid | output | 1 | Verdict outputs are meaningful |
| pass | output | 1 | 1 = backwards deterministic |
| bad_in | output | $clog2(NUM_INPUTS) | Input word of first offence |
| bad_dst | output | $clog2(NUM_STATES) | Target state of first offence |

## Verification
A corrupted scan index or a bitmap bit left over from an earlier scan cannot be seen until `done`. It then shows up as a wrong verdict, or as a wrong offending pair when two collisions are placed so that order matters, up to NUM_INPUTS*NUM_STATES cycles after start. A wrong scan counter shows up as `done` arriving off its exact cycle. A write that gets past the busy guard stays hidden until the following scan, so the tests run a second scan after each disturbed one.

// File: rtl/bd_pkg.sv
package bd_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SCAN = 1'b1
    } phase_e;
endpackage

// File: rtl/bd_table.sv
module bd_table #(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_STATES = 8,
    localparam int IW = $clog2(NUM_INPUTS),
    localparam int SW = $clog2(NUM_STATES),
    localparam int AW = IW + SW,
    localparam int ENTRIES = NUM_INPUTS * NUM_STATES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic          wvalid,
    input  logic [SW-1:0] wdst,
    input  logic [AW-1:0] raddr,
    output logic          rvalid,
    output logic [SW-1:0] rdst
);
    logic [ENTRIES-1:0] used_d, used_q;
    logic [SW-1:0]      tgt_d [ENTRIES];
    logic [SW-1:0]      tgt_q [ENTRIES];

    always_comb begin
        used_d = used_q;
        for (int k = 0; k < ENTRIES; k++) tgt_d[k] = tgt_q[k];
        if (we) begin
            used_d[waddr] = wvalid;
            tgt_d[waddr]  = wdst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= '0;
            for (int k = 0; k < ENTRIES; k++) tgt_q[k] <= '0;
        end else begin
            used_q <= used_d;
            for (int k = 0; k < ENTRIES; k++) tgt_q[k] <= tgt_d[k];
        end
    end

    assign rvalid = used_q[raddr];
    assign rdst   = tgt_q[raddr];
endmodule

// File: rtl/bd_seen.sv
module bd_seen #(
    parameter int ENTRIES = 32,
    localparam int AW = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          set,
    input  logic [AW-1:0] addr,
    output logic          hit
);
    logic [ENTRIES-1:0] bits_d, bits_q;

    always_comb begin
        bits_d = bits_q;
        if (clr) begin
            bits_d = '0;
        end else if (set) begin
            bits_d[addr] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits_q <= '0;
        else        bits_q <= bits_d;
    end

    assign hit = bits_q[addr];
endmodule

// File: rtl/bd_checker.sv
module bd_checker
    import bd_pkg::*;
#(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_STATES = 8,
    localparam int IW = $clog2(NUM_INPUTS),
    localparam int SW = $clog2(NUM_STATES),
    localparam int AW = IW + SW,
    localparam int ENTRIES = NUM_INPUTS * NUM_STATES
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_in,
    input  logic [SW-1:0] wr_src,
    input  logic          wr_valid,
    input  logic [SW-1:0] wr_dst,
    input  logic          start,
    output logic          busy,
    output logic          done,
    output logic          result_valid,
    output logic          pass,
    output logic [IW-1:0] bad_in,
    output logic [SW-1:0] bad_dst
);
    localparam logic [AW-1:0] LAST = AW'(ENTRIES - 1);

    typedef struct packed {
        phase_e        phase;
        logic [AW-1:0] idx;
        logic          done;
        logic          rvalid;
        logic          pass;
        logic [IW-1:0] bad_in;
        logic [SW-1:0] bad_dst;
    } ctrl_t;

    ctrl_t st_d, st_q;

    logic          tbl_we;
    logic          slot_used;
    logic [SW-1:0] slot_dst;
    logic [IW-1:0] cur_in;
    logic          seen_clr;
    logic          seen_set;
    logic          seen_hit;
    logic          accept;

    assign accept = start && (st_q.phase == PH_IDLE);
    assign tbl_we = wr_en && (st_q.phase == PH_IDLE);
    assign cur_in = st_q.idx[AW-1:SW];

    bd_table #(
        .NUM_INPUTS(NUM_INPUTS),
        .NUM_STATES(NUM_STATES)
    ) u_table (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (tbl_we),
        .waddr ({wr_in, wr_src}),
        .wvalid(wr_valid),
        .wdst  (wr_dst),
        .raddr (st_q.idx),
        .rvalid(slot_used),
        .rdst  (slot_dst)
    );

    bd_seen #(
        .ENTRIES(ENTRIES)
    ) u_seen (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (seen_clr),
        .set  (seen_set),
        .addr ({cur_in, slot_dst}),
        .hit  (seen_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.done = 1'b0;
        seen_clr = 1'b0;
        seen_set = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (start) begin
                    st_d.phase   = PH_SCAN;
                    st_d.idx     = '0;
                    st_d.rvalid  = 1'b0;
                    st_d.pass    = 1'b1;
                    st_d.bad_in  = '0;
                    st_d.bad_dst = '0;
                    seen_clr     = 1'b1;
                end
            end
            PH_SCAN: begin
                if (slot_used) begin
                    seen_set = 1'b1;
                    if (seen_hit && st_q.pass) begin
                        st_d.pass    = 1'b0;
                        st_d.bad_in  = cur_in;
                        st_d.bad_dst = slot_dst;
                    end
                end
                if (st_q.idx == LAST) begin
                    st_d.phase  = PH_IDLE;
                    st_d.done   = 1'b1;
                    st_d.rvalid = 1'b1;
                end else begin
                    st_d.idx = st_q.idx + AW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, done: 1'b0, rvalid: 1'b0,
                      pass: 1'b0, bad_in: '0, bad_dst: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy         = (st_q.phase == PH_SCAN);
    assign done         = st_q.done;
    assign result_valid = st_q.rvalid;
    assign pass         = st_q.pass && st_q.rvalid;
    assign bad_in       = st_q.bad_in;
    assign bad_dst      = st_q.bad_dst;
endmodule

// File: rtl/bd_checker_sva.sv
module bd_checker_sva #(
    parameter int NUM_INPUTS = 4,
    parameter int NUM_STATES = 8,
    localparam int IW = $clog2(NUM_INPUTS),
    localparam int SW = $clog2(NUM_STATES),
    localparam int ENTRIES = NUM_INPUTS * NUM_STATES,
    localparam int CW = $clog2(ENTRIES + 1) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          result_valid,
    input logic          pass,
    input logic [IW-1:0] bad_in,
    input logic [SW-1:0] bad_dst
);
    logic [CW-1:0] span_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               span_q <= '0;
        else if (start && !busy)  span_q <= '0;
        else if (busy)            span_q <= span_q + CW'(1);
    end

    a_r3_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r4_busy_done_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    a_r4_scan_length: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (span_q == CW'(ENTRIES)));

    a_r8_valid_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> result_valid);

    a_r8_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && !start) |=>
            (result_valid && $stable(pass) && $stable(bad_in) && $stable(bad_dst)));

    a_r7_pass_clean: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (bad_in == '0 && bad_dst == '0));
endmodule

bind bd_checker bd_checker_sva #(
    .NUM_INPUTS(NUM_INPUTS),
    .NUM_STATES(NUM_STATES)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .result_valid(result_valid),
    .pass        (pass),
    .bad_in      (bad_in),
    .bad_dst     (bad_dst)
);

// File: tb/tb_bd_checker.sv
`timescale 1ns/1ps
module tb_bd_checker;
    localparam int M  = 4;
    localparam int N  = 8;
    localparam int IW = $clog2(M);
    localparam int SW = $clog2(N);
    localparam int E  = M * N;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, wr_valid = 1'b0, start = 1'b0;
    logic [IW-1:0] wr_in = '0;
    logic [SW-1:0] wr_src = '0, wr_dst = '0;
    logic busy, done, result_valid, pass;
    logic [IW-1:0] bad_in;
    logic [SW-1:0] bad_dst;

    int checks = 0;
    int errors = 0;
    bit sh_v [M][N];
    int sh_d [M][N];

    always #10 clk = ~clk;

    bd_checker #(.NUM_INPUTS(M), .NUM_STATES(N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_in(wr_in), .wr_src(wr_src),
        .wr_valid(wr_valid), .wr_dst(wr_dst), .start(start), .busy(busy),
        .done(done), .result_valid(result_valid), .pass(pass),
        .bad_in(bad_in), .bad_dst(bad_dst)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input int s, input bit v, input int d);
        @(negedge clk);
        wr_en = 1'b1; wr_in = IW'(i); wr_src = SW'(s); wr_valid = v; wr_dst = SW'(d);
        @(negedge clk);
        wr_en = 1'b0;
        sh_v[i][s] = v;
        sh_d[i][s] = d;
    endtask

    task automatic load_perm();
        for (int i = 0; i < M; i++)
            for (int s = 0; s < N; s++)
                wr(i, s, 1'b1, (s + i + 1) % N);
    endtask

    task automatic model(output bit ep, output int ei, output int ed);
        bit seen [M][N];
        ep = 1'b1; ei = 0; ed = 0;
        for (int i = 0; i < M; i++)
            for (int s = 0; s < N; s++) seen[i][s] = 1'b0;
        for (int i = 0; i < M; i++)
            for (int s = 0; s < N; s++)
                if (sh_v[i][s]) begin
                    if (seen[i][sh_d[i][s]] && ep) begin
                        ep = 1'b0; ei = i; ed = sh_d[i][s];
                    end
                    seen[i][sh_d[i][s]] = 1'b1;
                end
    endtask

    // disturb=1: mid-scan write (discarded) and a second start (ignored)
    task automatic run_scan(input string tag, input bit disturb);
        bit ep; int ei, ed; int early;
        model(ep, ei, ed);
        early = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({tag, " R3 busy after start"}, busy, 1);
        chk({tag, " R8 result_valid cleared"}, result_valid, 0);
        for (int k = 0; k < E - 1; k++) begin
            @(negedge clk);
            if (done || !busy) early++;
            if (disturb && k == 4) begin
                start = 1'b1; wr_en = 1'b1; wr_in = '0; wr_src = SW'(1);
                wr_valid = 1'b1; wr_dst = SW'(sh_d[0][0]);
            end else begin
                start = 1'b0; wr_en = 1'b0;
            end
        end
        chk({tag, " R4 no early done"}, early, 0);
        @(negedge clk);
        chk({tag, " R4 done on exact cycle"}, done, 1);
        chk({tag, " R4 busy low at done"}, busy, 0);
        chk({tag, " R8 result_valid"}, result_valid, 1);
        chk({tag, " R5 verdict"}, pass, ep);
        chk({tag, " R7 bad_in"}, bad_in, ei);
        chk({tag, " R7 bad_dst"}, bad_dst, ed);
        @(negedge clk);
        chk({tag, " R4 done single cycle"}, done, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 result_valid", result_valid, 0);
        chk("R1 pass", pass, 0);
        chk("R1 bad fields", {bad_in, bad_dst}, 0);
        run_scan("R1 empty table", 1'b0);
    endtask

    task automatic t_perm();
        load_perm();
        run_scan("R5 permutation", 1'b0);
    endtask

    task automatic t_order();
        // input 2 normally maps s -> s+3; make two collisions within input 2
        wr(2, 6, 1'b1, 6);   // collides with src3 -> 6, found at src6
        wr(2, 7, 1'b1, 0);   // collides with src5 -> 0, found at src7
        wr(3, 1, 1'b1, 4);   // later input also collides
        run_scan("R7 first offence", 1'b0);
        chk("R7 expected pair in", bad_in, 2);
        chk("R7 expected pair dst", bad_dst, 6);
    endtask

    task automatic t_invalid();
        load_perm();
        wr(1, 0, 1'b0, 5);   // unused slot pointing at a reached target
        wr(1, 3, 1'b0, 5);
        run_scan("R6 unused skipped", 1'b0);
        chk("R9 clean after failing scan", pass, 1);
    endtask

    task automatic t_busy();
        run_scan("R2 R3 disturbed scan", 1'b1);
        run_scan("R2 write while busy discarded", 1'b0);
        chk("R2 discarded write left no duplicate", pass, 1);
        wr(0, 1, 1'b1, sh_d[0][0]);
        run_scan("R2 idle write stored", 1'b0);
        chk("R2 idle write verdict", pass, 0);
    endtask

    task automatic t_hold();
        logic [IW+SW:0] snap;
        snap = {pass, bad_in, bad_dst};
        repeat (20) @(negedge clk);
        chk("R8 result_valid held", result_valid, 1);
        chk("R8 result held", {pass, bad_in, bad_dst}, snap);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_perm();
        t_order();
        t_hold();
        t_invalid();
        t_busy();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule